// File: doc/BRIEF.md
# MSI Doorbell Interrupt Aggregator

This block receives message-signalled interrupts for a single PCIe controller. An endpoint raises vector `n` by writing a doorbell word to offset 0 of the block. The vector index sits three bits up inside that word. The block holds one sticky pending bit per vector, for 32 vectors, and drives one registered level interrupt toward the host interrupt controller whenever any bit is pending.

Inbound messages arrive on a write-only port fed by the PCIe controller. Host software uses a separate 32-bit register port. On that port, software reads the status word at offset 4 to learn which vectors are pending. The order of the status bits is reversed, so vector `n` shows at logical bit `31-n`. The read clears exactly the bits it returned. Both ports carry big-endian words, and lane swapping inside the block restores the logical bit layout. Host writes to the doorbell offset act like inbound messages.

Top module: `msi_doorbell_agg`

## Requirements
- R1: A doorbell write (inbound port, or host port with `h_wr`=1) to byte offset 0 sets pending vector `idx`, where `idx` = logical data bits [7:3]. Logical bits [2:0] and bits [31:8] are ignored.
- R2: A host read of byte offset 4 returns a logical status word in which vector `n` appears at bit `31-n`.
- R3: Both ports are big-endian. Logical byte `k` (bits [8k+7:8k]) travels on bus bits [31-8k -: 8], in both directions. A bus write of 0x00000008 therefore raises vector 0, and vector 31 reads back as bus value 0x01000000.
- R4: Several vectors pending at once are all reported in one status read.
- R5: A status read clears exactly the bits it returned. A doorbell write in the same cycle stays pending and shows in the next read.
- R6: A doorbell write to a vector that is already pending leaves it pending once. Repeats are not counted.
- R7: `irq` is registered. It equals the OR of the pending bits one clock earlier, so it rises the cycle after the first set and falls the cycle after the read that clears the last bit.
- R8: After reset all pending bits are 0 and `irq` is low.
- R9: A host write to offset 4 changes nothing. A host read of offset 0 returns 0 and clears nothing.
- R10: `h_rvalid` is high exactly in the cycle after each host read, with `h_rdata` valid in that cycle. `h_rdata` is 0 in other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inbound message write strobe |
| in_addr | input | 4 | Inbound byte offset |
| in_data | input | 32 | Inbound write data, big-endian lanes |
| h_sel | input | 1 | Host access request |
| h_wr | input | 1 | Host access is a write when 1 |
| h_addr | input | 4 | Host byte offset |
| h_wdata | input | 32 | Host write data, big-endian lanes |
| h_rdata | output | 32 | Host read data, big-endian lanes |
| h_rvalid | output | 1 | Host read data valid |
| irq | output | 1 | Summary interrupt level |

## Verification
The first pattern is single vectors at both ends of the index range, written with junk in the low three bits. It separates a correct bit reversal and lane swap from a mirrored or unswapped mapping. A bus word carrying the index in the wrong lane shows whether byte swapping is applied on the write side. Groups of vectors followed by one read, with repeated writes to the same vector, show whether all pending bits are reported and whether repeats collapse into one. A status read in the same cycle as an inbound write, and host accesses to the wrong offsets, show whether clearing is limited to the returned bits and whether the wrong offsets touch the pending state.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
   localparam int unsigned BUS_W = 32;

   function automatic logic [BUS_W-1:0] lane_swap32(input logic [BUS_W-1:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction
endpackage

// File: rtl/msi_lane_swap.sv
module msi_lane_swap #(
   parameter int unsigned DATA_W     = 32,
   parameter bit          BIG_ENDIAN = 1'b1
) (
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int unsigned NBYTES = DATA_W / 8;

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("msi_lane_swap: DATA_W must be a whole number of bytes");
   end

   if (BIG_ENDIAN) begin : g_swap
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
         assign dout[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
      end
   end else begin : g_pass
      assign dout = din;
   end
endmodule

// File: rtl/msi_reg_decode.sv
module msi_reg_decode #(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_VEC   = 32,
   parameter int unsigned IDX_SHIFT = 3,
   parameter int unsigned DB_OFF    = 0,
   parameter int unsigned ST_OFF    = 4
) (
   input  logic              req,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata_log,
   output logic [NUM_VEC-1:0] set_vec,
   output logic              st_rd
);
   localparam int unsigned IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

   if (IDX_SHIFT + IDX_W > DATA_W) begin : g_bad_shift
      $error("msi_reg_decode: index field does not fit the data word");
   end
   if (DB_OFF == ST_OFF) begin : g_bad_off
      $error("msi_reg_decode: register offsets must differ");
   end

   logic [IDX_W-1:0] idx;
   logic             db_hit;
   logic             unused_data;

   assign idx         = wdata_log[IDX_SHIFT +: IDX_W];
   assign unused_data = ^wdata_log;
   assign db_hit      = req && wr && (addr == ADDR_W'(DB_OFF));
   assign st_rd       = req && !wr && (addr == ADDR_W'(ST_OFF));

   always_comb begin
      set_vec = '0;
      if (db_hit) set_vec[idx] = 1'b1;
   end
endmodule

// File: rtl/msi_pending_array.sv
module msi_pending_array #(
   parameter int unsigned NUM_VEC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] set_vec,
   input  logic [NUM_VEC-1:0] clr_vec,
   output logic [NUM_VEC-1:0] pend
);
   for (genvar v = 0; v < NUM_VEC; v++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          pend[v] <= 1'b0;
         else if (set_vec[v]) pend[v] <= 1'b1;
         else if (clr_vec[v]) pend[v] <= 1'b0;
      end
   end
endmodule

// File: rtl/msi_status_fmt.sv
module msi_status_fmt #(
   parameter int unsigned NUM_VEC = 32,
   parameter bit          REVERSE = 1'b1
) (
   input  logic [NUM_VEC-1:0] pend,
   output logic [NUM_VEC-1:0] status
);
   if (REVERSE) begin : g_rev
      for (genvar n = 0; n < NUM_VEC; n++) begin : g_map
         assign status[NUM_VEC-1-n] = pend[n];
      end
   end else begin : g_fwd
      assign status = pend;
   end
endmodule

// File: rtl/msi_irq_out.sv
module msi_irq_out #(
   parameter int unsigned NUM_VEC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] pend,
   output logic               irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |pend;
   end
endmodule

// File: rtl/msi_doorbell_agg.sv
module msi_doorbell_agg #(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned NUM_VEC     = 32,
   parameter int unsigned IDX_SHIFT   = 3,
   parameter int unsigned DB_OFF      = 0,
   parameter int unsigned ST_OFF      = 4,
   parameter bit          BIG_ENDIAN  = 1'b1,
   parameter bit          REVERSE_ST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   input  logic              h_sel,
   input  logic              h_wr,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic [DATA_W-1:0] h_wdata,
   output logic [DATA_W-1:0] h_rdata,
   output logic              h_rvalid,
   output logic              irq
);
   if (NUM_VEC != DATA_W) begin : g_bad_vec
      $error("msi_doorbell_agg: NUM_VEC must equal DATA_W");
   end
   if (DB_OFF >= (1 << ADDR_W) || ST_OFF >= (1 << ADDR_W)) begin : g_bad_addr
      $error("msi_doorbell_agg: offsets exceed address width");
   end

   logic [DATA_W-1:0]  in_log, h_log, stat_log, stat_bus;
   logic [NUM_VEC-1:0] set_in, set_h, set_all, clr_vec, pend_vec;
   logic               st_rd, unused_in_strd;

   msi_lane_swap #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_swap_in (
      .din(in_data), .dout(in_log));
   msi_lane_swap #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_swap_h (
      .din(h_wdata), .dout(h_log));

   msi_reg_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_VEC(NUM_VEC),
      .IDX_SHIFT(IDX_SHIFT), .DB_OFF(DB_OFF), .ST_OFF(ST_OFF)
   ) u_dec_in (
      .req(in_valid), .wr(1'b1), .addr(in_addr), .wdata_log(in_log),
      .set_vec(set_in), .st_rd(unused_in_strd));

   msi_reg_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_VEC(NUM_VEC),
      .IDX_SHIFT(IDX_SHIFT), .DB_OFF(DB_OFF), .ST_OFF(ST_OFF)
   ) u_dec_h (
      .req(h_sel), .wr(h_wr), .addr(h_addr), .wdata_log(h_log),
      .set_vec(set_h), .st_rd(st_rd));

   assign set_all = set_in | set_h;
   // the read returns the current pending word, so exactly those bits clear
   assign clr_vec = st_rd ? pend_vec : '0;

   msi_pending_array #(.NUM_VEC(NUM_VEC)) u_pend (
      .clk(clk), .rst_n(rst_n), .set_vec(set_all), .clr_vec(clr_vec),
      .pend(pend_vec));

   msi_status_fmt #(.NUM_VEC(NUM_VEC), .REVERSE(REVERSE_ST)) u_fmt (
      .pend(pend_vec), .status(stat_log));

   msi_lane_swap #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_swap_rd (
      .din(stat_log), .dout(stat_bus));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_rdata  <= '0;
         h_rvalid <= 1'b0;
      end else begin
         h_rdata  <= st_rd ? stat_bus : '0;
         h_rvalid <= h_sel && !h_wr;
      end
   end

   msi_irq_out #(.NUM_VEC(NUM_VEC)) u_irq (
      .clk(clk), .rst_n(rst_n), .pend(pend_vec), .irq(irq));
endmodule

// File: rtl/msi_agg_checker.sv
module msi_agg_checker #(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned NUM_VEC = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [ADDR_W-1:0]  in_addr,
   input logic [31:0]        in_data,
   input logic               h_sel,
   input logic               h_wr,
   input logic [ADDR_W-1:0]  h_addr,
   input logic [31:0]        h_rdata,
   input logic               h_rvalid,
   input logic               irq,
   input logic [NUM_VEC-1:0] pend
);
   logic       in_db, st_read, db_read;
   logic [4:0] in_idx;

   assign in_db   = in_valid && (in_addr == '0);
   assign st_read = h_sel && !h_wr && (h_addr == ADDR_W'(4));
   assign db_read = h_sel && !h_wr && (h_addr == '0);
   assign in_idx  = in_data[31:27]; // logical bits [7:3] live in the top bus lane

   a_r1_inbound_sets: assert property (@(posedge clk) disable iff (!rst_n)
      in_db |=> pend[$past(in_idx)]);
   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      st_read && !in_valid && !h_wr |=> pend == '0);
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !st_read |=> (pend & $past(pend)) == $past(pend));
   a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq == $past(|pend));
   a_r8_reset_state: assert property (@(posedge clk)
      !rst_n |=> (pend == '0 && !irq));
   a_r9_db_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      db_read |=> h_rdata == '0 && pend == $past(pend | '0) || $past(in_valid));
   a_r10_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
      (h_sel && !h_wr) |=> h_rvalid);
   a_r10_rvalid_only: assert property (@(posedge clk) disable iff (!rst_n)
      !(h_sel && !h_wr) |=> !h_rvalid && h_rdata == '0);
endmodule

bind msi_doorbell_agg msi_agg_checker #(.ADDR_W(ADDR_W), .NUM_VEC(NUM_VEC)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
   .in_data(in_data), .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr),
   .h_rdata(h_rdata), .h_rvalid(h_rvalid), .irq(irq), .pend(pend_vec));

// File: tb/tb_msi_doorbell_agg.sv
module tb_msi_doorbell_agg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  in_addr = '0;
   logic [31:0] in_data = '0;
   logic        h_sel = 1'b0, h_wr = 1'b0;
   logic [3:0]  h_addr = '0;
   logic [31:0] h_wdata = '0;
   logic [31:0] h_rdata;
   logic        h_rvalid, irq;

   int checks = 0, fails = 0;
   logic [31:0] model = '0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   bit          done = 1'b0;

   always #5 clk = ~clk;

   msi_doorbell_agg dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
      .in_data(in_data), .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr),
      .h_wdata(h_wdata), .h_rdata(h_rdata), .h_rvalid(h_rvalid), .irq(irq));

   function automatic logic [31:0] swp(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   function automatic logic [31:0] status_bus(input logic [31:0] p);
      logic [31:0] lg;
      for (int n = 0; n < 32; n++) lg[31-n] = p[n];
      return swp(lg);
   endfunction

   function automatic logic [31:0] db_word(input int idx, input logic [2:0] junk);
      return swp({24'h0, idx[4:0], junk});
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one bus cycle: drives both ports, updates the model, queues a read expectation
   task automatic step(input bit hs, input bit hw, input logic [3:0] ha,
                       input logic [31:0] hd, input bit iv, input logic [31:0] id,
                       input string tag);
      logic [31:0] pre, setm, clrm;
      pre  = model;
      setm = '0;
      clrm = '0;
      if (iv) setm[swp(id)[7:3]] = 1'b1;
      if (hs && hw && ha == 4'd0) setm[swp(hd)[7:3]] = 1'b1;
      if (hs && !hw) begin
         exp_q.push_back(ha == 4'd4 ? status_bus(pre) : 32'h0);
         tag_q.push_back(tag);
         if (ha == 4'd4) clrm = pre;
      end
      h_sel = hs; h_wr = hw; h_addr = ha; h_wdata = hd;
      in_valid = iv; in_addr = 4'd0; in_data = id;
      @(negedge clk);
      h_sel = 1'b0; h_wr = 1'b0; in_valid = 1'b0;
      model = (pre & ~clrm) | setm;
      check("R7 irq", {31'h0, irq}, {31'h0, |pre});
   endtask

   task automatic in_wr(input int idx, input logic [2:0] junk);
      step(0, 0, 0, 0, 1, db_word(idx, junk), "R1");
   endtask

   task automatic rd_status(input string tag);
      step(1, 0, 4'd4, 0, 0, 0, tag);
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, "idle");
   endtask

   // monitor: pops expectations as read data appears
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         if (h_rvalid) begin
            if (exp_q.size() == 0) begin
               checks++; fails++;
               $display("FAIL R10 actual=unexpected_rvalid expected=none");
            end else begin
               logic [31:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(t, h_rdata, e);
            end
         end else begin
            check("R10 idle rdata", h_rdata, 32'h0);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R8 irq after reset", {31'h0, irq}, 32'h0);
      check("R8 rdata after reset", h_rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_status("R8 empty status");
      // R1/R2: single vectors with junk low bits, both ends of range
      in_wr(5, 3'b111);  rd_status("R2 vector5");
      in_wr(31, 3'b101); rd_status("R3 vector31");
      check("R3 vector31 lane", status_bus(32'h8000_0000), 32'h0100_0000);
      in_wr(0, 3'b010);  rd_status("R2 vector0");
      // R3: index placed in the wrong lane maps to vector 0
      step(0, 0, 0, 0, 1, 32'h0000_0008, "R3"); rd_status("R3 unswapped word");
      // R4: several pending together
      in_wr(0, 0); in_wr(7, 0); in_wr(16, 1); in_wr(31, 0);
      rd_status("R4 multi");
      // R6: repeats collapse
      in_wr(9, 0); in_wr(9, 4); in_wr(9, 0);
      rd_status("R6 repeat"); rd_status("R6 after clear");
      // R5: read concurrent with new write
      in_wr(3, 0);
      step(1, 0, 4'd4, 0, 1, db_word(12, 0), "R5 concurrent read");
      rd_status("R5 survivor");
      // R7: irq timing after set and after clear
      in_wr(20, 0); idle(); rd_status("R7 clear"); idle(); idle();
      check("R7 irq low after clear", {31'h0, irq}, 32'h0);
      // R9: wrong-offset accesses
      in_wr(14, 0);
      step(1, 1, 4'd4, 32'hFFFF_FFFF, 0, 0, "R9");
      step(1, 0, 4'd0, 0, 0, 0, "R9 doorbell read");
      rd_status("R9 status intact");
      // R1 via host doorbell write
      step(1, 1, 4'd0, db_word(27, 3'b111), 0, 0, "R1");
      rd_status("R1 host doorbell");
      // R10: read of unmapped offset
      step(1, 0, 4'd8, 0, 0, 0, "R10 unmapped read");
      idle(); idle();
      check("R10 queue drained", exp_q.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule